// File: doc/BRIEF.md
# Stop-Mode Oscillator Restart Sequencer

This block runs the processor's deepest low-power state. It runs from an always-on clock at T rate, so one `clk` period is one T cycle and four of them make one instruction cycle. When the core decodes a stop command, the block spends a short entry phase with clocks still running. In the first cycle of that phase it pulses a clear for the peripheral and external interrupt pendings. It then shuts off the oscillator, gates the core clock and holds the peripherals in reset.

A low level on the active-low interrupt request line, or a timer-expiry flag, wakes the block. The oscillator comes back at once, and a stabilization count runs with the core clock still gated. The count is 16 or 131,072 T cycles, as a delay-select input picks. During that count a clear for edge-triggered requests is held active.

A fixed tail of 17 T cycles follows the count. The core clock runs during the tail and the peripherals leave reset. At the end of the tail the block makes a single decision. If the request line is configured level-sensitive, was low for the whole tail and no stack error is pending, the block strobes "take interrupt". Otherwise it strobes "resume at next instruction". A synchronous reset ends the sequence at once from any phase.

Top module: `stop_seq_ctrl`

## Requirements
- R1: While `rst` is high and after it, with no stop requested, `osc_en`=1, `core_clk_en`=1, `periph_hold`=0, and `pend_clr`, `edge_clr`, `take_irqa`, `resume` are all 0.
- R2: A `stop_dec` pulse seen with the core running makes `pend_clr` high for exactly the next cycle. Clocks stay on for 4 cycles. If `irqa_n` is then high, the block enters the off state with `osc_en`=0, `core_clk_en`=0 and `periph_hold`=1.
- R3: In the off state, `irqa_n`=0 or `tmr_zero`=1 at a clock edge sets `osc_en`=1 from the next cycle. `core_clk_en` stays 0 during that cycle.
- R4: The delay lasts exactly 16 cycles when `sd`=1 and exactly 131,072 cycles when `sd`=0. The delay is the run of cycles with `osc_en`=1 and `core_clk_en`=0.
- R5: `edge_clr` is 1 in every delay cycle and in no other cycle.
- R6: `periph_hold` falls in the same cycle that `core_clk_en` rises. Exactly 17 cycles with the core clock on separate the end of the delay from the decision strobe.
- R7: `take_irqa` is a one-cycle strobe in the cycle after the tail. It fires only if all three of these hold in the last tail cycle: `irqa_level`=1 (level-sensitive), `irqa_n` was 0 in every tail cycle, and `stk_err`=0.
- R8: In every other case the tail ends with a one-cycle `resume` strobe. This covers edge mode (`irqa_level`=0), `irqa_n` released during the tail, a timer-only wake, and a pending stack error.
- R9: If `irqa_n` is already 0 when the entry phase ends, `osc_en` never drops. The core clock is still gated for the full delay.
- R10: `rst` raised in the off state restores `osc_en`=1, `core_clk_en`=1 and `periph_hold`=0 on the next cycle. No delay runs and no strobe follows.
- R11: `take_irqa` and `resume` are never high together. Exactly one of them fires after each tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on T-rate clock |
| rst | input | 1 | Synchronous active-high reset; also a wake source |
| stop_dec | input | 1 | Stop command decoded by the core |
| irqa_n | input | 1 | Interrupt request line, active low |
| irqa_level | input | 1 | 1 = request line level-sensitive, 0 = edge-triggered |
| tmr_zero | input | 1 | On-chip timer reached zero |
| sd | input | 1 | Delay select: 1 = short (16), 0 = long (131,072) |
| stk_err | input | 1 | Stack-error interrupt pending (kept across stop) |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock enable |
| periph_hold | output | 1 | Holds peripherals in reset |
| pend_clr | output | 1 | Clears peripheral and external interrupt pendings |
| edge_clr | output | 1 | Clears edge-triggered requests during the delay |
| take_irqa | output | 1 | Strobe: vector to the request-line interrupt |
| resume | output | 1 | Strobe: continue at the next sequential instruction |

## Verification
The assertions assume that `sd` is stable while a delay runs. They also assume that `rst` is held for more than one cycle at power-up, so the first sampled output values are the reset values. The stimulus changes `sd`, `irqa_level` and `stk_err` only while the core runs. It drives every input on falling clock edges and keeps `stop_dec` as a single-cycle pulse, so the wake, release and reset events each fall into a known phase of the sequence.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;

    typedef enum logic [2:0] {
        PH_RUN,
        PH_ENTRY,
        PH_OFF,
        PH_DELAY,
        PH_TAIL
    } phase_e;

    typedef struct packed {
        logic osc;
        logic clk;
        logic hold;
        logic eclr;
    } gate_s;

    function automatic gate_s gates_of(phase_e p);
        gate_s g;
        g = '{osc: 1'b1, clk: 1'b1, hold: 1'b0, eclr: 1'b0};
        case (p)
            PH_OFF:   g = '{osc: 1'b0, clk: 1'b0, hold: 1'b1, eclr: 1'b0};
            PH_DELAY: g = '{osc: 1'b1, clk: 1'b0, hold: 1'b1, eclr: 1'b1};
            default:  g = '{osc: 1'b1, clk: 1'b1, hold: 1'b0, eclr: 1'b0};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/stop_delay_cnt.sv
module stop_delay_cnt #(
    parameter int LONG_T  = 131072,
    parameter int SHORT_T = 16,
    parameter int W       = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic sd,
    input  logic run,
    output logic done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= sd ? W'(SHORT_T - 1) : W'(LONG_T - 1);
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == '0);
endmodule

// File: rtl/stop_irqa_qual.sv
module stop_irqa_qual (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic track,
    input  logic irqa_n,
    output logic held
);
    logic ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            ok <= 1'b0;
        end else if (arm) begin
            ok <= ~irqa_n;
        end else if (track) begin
            ok <= ok & ~irqa_n;
        end
    end

    assign held = ok & ~irqa_n;
endmodule

// File: rtl/stop_seq_ctrl.sv
module stop_seq_ctrl
    import stop_seq_pkg::*;
#(
    parameter int LONG_T  = 131072,
    parameter int SHORT_T = 16,
    parameter int ENTRY_T = 4,
    parameter int TAIL_T  = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic stop_dec,
    input  logic irqa_n,
    input  logic irqa_level,
    input  logic tmr_zero,
    input  logic sd,
    input  logic stk_err,
    output logic osc_en,
    output logic core_clk_en,
    output logic periph_hold,
    output logic pend_clr,
    output logic edge_clr,
    output logic take_irqa,
    output logic resume
);
    localparam int CNT_W   = $clog2(LONG_T + 1);
    localparam int SEQ_MAX = (ENTRY_T > TAIL_T) ? ENTRY_T : TAIL_T;
    localparam int SEQ_W   = $clog2(SEQ_MAX + 1);

    phase_e           ph;
    logic [SEQ_W-1:0] seq;
    logic             dly_load, dly_done, held, wake, seq_end;
    gate_s            g;

    assign wake     = ~irqa_n | tmr_zero;
    assign seq_end  = (seq == '0);
    assign dly_load = (ph == PH_ENTRY && seq_end && ~irqa_n) ||
                      (ph == PH_OFF && wake);

    stop_delay_cnt #(.LONG_T(LONG_T), .SHORT_T(SHORT_T), .W(CNT_W)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .load (dly_load),
        .sd   (sd),
        .run  (ph == PH_DELAY),
        .done (dly_done)
    );

    stop_irqa_qual u_qual (
        .clk    (clk),
        .rst    (rst),
        .arm    (dly_done),
        .track  (ph == PH_TAIL),
        .irqa_n (irqa_n),
        .held   (held)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_RUN;
            seq       <= '0;
            take_irqa <= 1'b0;
            resume    <= 1'b0;
        end else begin
            take_irqa <= 1'b0;
            resume    <= 1'b0;
            case (ph)
                PH_RUN: if (stop_dec) begin
                    ph  <= PH_ENTRY;
                    seq <= SEQ_W'(ENTRY_T - 1);
                end
                PH_ENTRY: if (seq_end) ph <= irqa_n ? PH_OFF : PH_DELAY;
                          else         seq <= seq - 1'b1;
                PH_OFF: if (wake) ph <= PH_DELAY;
                PH_DELAY: if (dly_done) begin
                    ph  <= PH_TAIL;
                    seq <= SEQ_W'(TAIL_T - 1);
                end
                PH_TAIL: if (seq_end) begin
                    ph        <= PH_RUN;
                    take_irqa <= irqa_level & held & ~stk_err;
                    resume    <= ~(irqa_level & held & ~stk_err);
                end else begin
                    seq <= seq - 1'b1;
                end
                default: ph <= PH_RUN;
            endcase
        end
    end

    assign g           = gates_of(ph);
    assign osc_en      = g.osc;
    assign core_clk_en = g.clk;
    assign periph_hold = g.hold;
    assign edge_clr    = g.eclr;
    assign pend_clr    = (ph == PH_ENTRY) && (seq == SEQ_W'(ENTRY_T - 1));
endmodule

// File: rtl/stop_seq_chk.sv
module stop_seq_chk #(
    parameter int LONG_T  = 131072,
    parameter int SHORT_T = 16
) (
    input logic clk,
    input logic rst,
    input logic stop_dec,
    input logic irqa_n,
    input logic irqa_level,
    input logic tmr_zero,
    input logic sd,
    input logic stk_err,
    input logic osc_en,
    input logic core_clk_en,
    input logic periph_hold,
    input logic pend_clr,
    input logic edge_clr,
    input logic take_irqa,
    input logic resume
);
    logic [31:0] win;
    logic        sd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win  <= '0;
            sd_q <= 1'b0;
        end else begin
            win  <= (osc_en && !core_clk_en) ? win + 1 : '0;
            sd_q <= sd;
        end
    end

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(take_irqa && resume));

    // R6
    hold_vs_clk_chk: assert property (@(posedge clk) disable iff (rst)
        periph_hold == !core_clk_en);

    // R3
    clk_needs_osc_chk: assert property (@(posedge clk) disable iff (rst)
        core_clk_en |-> osc_en);

    // R3
    osc_wake_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(osc_en) && !$past(rst)) |-> (!core_clk_en && $past(!irqa_n || tmr_zero)));

    // R5
    edge_clr_window_chk: assert property (@(posedge clk) disable iff (rst)
        edge_clr |-> (osc_en && !core_clk_en));

    // R2
    pend_clr_cause_chk: assert property (@(posedge clk) disable iff (rst)
        pend_clr |-> ($past(stop_dec) && core_clk_en));

    // R7
    take_cond_chk: assert property (@(posedge clk) disable iff (rst)
        take_irqa |-> ($past(irqa_level) && $past(!irqa_n) && $past(!stk_err)));

    // R4
    delay_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(osc_en && !core_clk_en) && core_clk_en && !$past(rst)) |->
        (win == (sd_q ? 32'(SHORT_T) : 32'(LONG_T))));
endmodule

bind stop_seq_ctrl stop_seq_chk #(.LONG_T(LONG_T), .SHORT_T(SHORT_T)) chk_i (.*);

// File: tb/stop_seq_ctrl_test.sv
module stop_seq_ctrl_test;
    localparam int TAIL_T = 17;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_dec = 1'b0, irqa_n = 1'b1, irqa_level = 1'b1;
    logic tmr_zero = 1'b0, sd = 1'b1, stk_err = 1'b0;
    logic osc_en, core_clk_en, periph_hold, pend_clr, edge_clr, take_irqa, resume;

    typedef struct { bit take; int dly; } exp_t;
    exp_t exp_q[$];

    int n_chk = 0, n_fail = 0, n_strobe = 0;
    int dcnt = 0, tcnt = 0, edge_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    stop_seq_ctrl uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor: scoreboard side
    always @(negedge clk) begin
        if (rst) begin
            dcnt = 0; tcnt = 0; edge_bad = 0;
        end else begin
            if (edge_clr != (osc_en && !core_clk_en)) edge_bad++;
            if (take_irqa || resume) begin
                exp_t e;
                n_strobe++;
                chk(!(take_irqa && resume), "R11 exclusive strobes", int'(take_irqa & resume), 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R11 unexpected strobe", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(take_irqa == e.take, "R7/R8 take_irqa", int'(take_irqa), int'(e.take));
                    chk(dcnt == e.dly, "R4 delay length", dcnt, e.dly);
                    chk(tcnt == TAIL_T, "R6 tail length", tcnt, TAIL_T);
                    chk(edge_bad == 0, "R5 edge_clr window", edge_bad, 0);
                end
                dcnt = 0; tcnt = 0; edge_bad = 0;
            end else if (osc_en && !core_clk_en) begin
                dcnt++;
            end else if (core_clk_en && dcnt > 0) begin
                tcnt++;
            end
        end
    end

    // driver: pushes expectations and walks one stop sequence
    task automatic stop_cycle(input bit lvl, input bit stk, input bit sdv, input bit use_tmr,
                              input bit rel_tail, input bit take_exp, input int dly_exp);
        exp_t e;
        irqa_level = lvl; stk_err = stk; sd = sdv;
        e.take = take_exp; e.dly = dly_exp;
        exp_q.push_back(e);
        @(negedge clk) stop_dec = 1'b1;
        @(negedge clk) stop_dec = 1'b0;
        chk(pend_clr == 1'b1, "R2 pend_clr pulse", int'(pend_clr), 1);
        repeat (4) @(negedge clk);
        chk({osc_en, core_clk_en, periph_hold} == 3'b001, "R2 off state",
            int'({osc_en, core_clk_en, periph_hold}), 1);
        if (use_tmr) tmr_zero = 1'b1; else irqa_n = 1'b0;
        @(negedge clk) tmr_zero = 1'b0;
        chk(osc_en && !core_clk_en, "R3 oscillator back, core gated",
            int'({osc_en, core_clk_en}), 2);
        while (!core_clk_en) @(negedge clk);
        chk(periph_hold == 1'b0, "R6 hold released with clock", int'(periph_hold), 0);
        if (rel_tail) begin
            repeat (5) @(negedge clk);
            irqa_n = 1'b1;
        end
        while (!(take_irqa || resume)) @(negedge clk);
        irqa_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({osc_en, core_clk_en, periph_hold, pend_clr, edge_clr, take_irqa, resume} == 7'b1100000,
            "R1 reset outputs",
            int'({osc_en, core_clk_en, periph_hold, pend_clr, edge_clr, take_irqa, resume}), 7'b1100000);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(osc_en && core_clk_en && !periph_hold, "R1 idle run", int'(osc_en), 1);

        stop_cycle(1, 0, 1, 0, 0, 1, 16); // R7 level, held low
        stop_cycle(1, 0, 1, 1, 0, 0, 16); // R8 timer wake
        stop_cycle(0, 0, 1, 0, 0, 0, 16); // R8 edge mode
        stop_cycle(1, 0, 1, 0, 1, 0, 16); // R8 release during tail
        stop_cycle(1, 1, 1, 0, 0, 0, 16); // R8 stack error pending

        // R9: stop with the request already low
        begin
            exp_t e;
            bit dropped = 0;
            e.take = 1; e.dly = 16;
            exp_q.push_back(e);
            irqa_level = 1; stk_err = 0; sd = 1; irqa_n = 1'b0;
            @(negedge clk) stop_dec = 1'b1;
            @(negedge clk) stop_dec = 1'b0;
            while (!(take_irqa || resume)) begin
                if (!osc_en) dropped = 1;
                @(negedge clk);
            end
            chk(!dropped, "R9 oscillator kept on", int'(dropped), 0);
            irqa_n = 1'b1;
            @(negedge clk);
        end

        // R10: reset wake from the off state
        begin
            int s0;
            @(negedge clk) stop_dec = 1'b1;
            @(negedge clk) stop_dec = 1'b0;
            repeat (4) @(negedge clk);
            chk(!osc_en, "R10 reached off state", int'(osc_en), 0);
            s0 = n_strobe;
            rst = 1'b1;
            @(negedge clk) rst = 1'b0;
            chk({osc_en, core_clk_en, periph_hold} == 3'b110, "R10 immediate restart",
                int'({osc_en, core_clk_en, periph_hold}), 6);
            repeat (30) @(negedge clk);
            chk(n_strobe == s0, "R10 no strobe after reset wake", n_strobe, s0);
        end

        stop_cycle(1, 0, 0, 1, 0, 0, 131072); // R4 long delay, timer wake

        chk(exp_q.size() == 0, "R11 every tail strobed once", exp_q.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule